// File: doc/BRIEF.md
# IEEE 802.15.4 Transmit Frame Sequencer

This block turns one PHY frame into a byte stream for a modulator. After a start command it emits a synchronisation header that it builds itself: a run of zero bytes, then the delimiter byte. It then forwards the length byte and the MAC payload bytes from a transmit FIFO, and closes the frame with a 16-bit frame check sequence that it computes on the fly. Spreading, modulation and the radio are handled downstream.

Both data paths use valid/ready. On the FIFO side the block asserts `fifo_pop_o` in exactly the cycle in which it consumes `fifo_data_i`. A FIFO word is taken only when `fifo_valid_i` is high. The data must stay put while `fifo_valid_i` is high and no pop has occurred.

On the modulator side a byte moves on every rising edge at which `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, a generated byte (header or check sequence) is held unchanged. The modulator may withhold ready for any number of cycles.

During the length and payload fields the byte comes straight from the FIFO. If the modulator asks for a byte there (`tx_ready_i` high) and the FIFO has none, the frame is aborted as an underflow.

Frame timing is visible on two outputs:
- a delimiter status level, which is high from the end of the delimiter byte until the end of the frame;
- a one-cycle interrupt request, which pulses when the delimiter byte has been handed over.

Top module: `tx_frame_seq`

## Requirements
- R1: After reset, `tx_valid_o`, `fifo_pop_o`, `sfd_o`, `sfd_irq_o` and `underflow_o` are all low.
- R2: A start accepted in idle produces four 0x00 bytes followed by one 0xA7 byte, in that order. `fifo_pop_o` stays low throughout these five bytes.
- R3: The next byte is the length byte, taken from the FIFO. It is followed by exactly len-2 payload bytes from the FIFO, where len is bits [6:0] of the length byte. Bit 7 is forwarded unchanged but does not affect the count. Each forwarded byte is popped once, in its transfer cycle.
- R4: After the last payload byte come two check bytes. They hold a CRC with polynomial x^16+x^12+x^5+1 and initial value 0, processed least significant bit first, over the payload bytes only. The low byte (CRC bits 7:0) is sent first.
- R5: A byte transfers only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` keeps its value.
- R6: `sfd_o` rises in the cycle after the 0xA7 byte transfers. `sfd_irq_o` is high for exactly that one cycle.
- R7: `sfd_o` falls in the cycle after the second check byte transfers. In that same cycle `tx_valid_o` is low and the block is idle.
- R8: Underflow occurs when, during the length or payload field, `tx_ready_i` is high and `fifo_valid_i` is low. From the next cycle on, the frame stops: `tx_valid_o` and `sfd_o` are low and `underflow_o` is high. `underflow_o` stays high until the next accepted start and clears in the cycle after it.
- R9: A start while a frame is in progress is ignored. The frame continues unchanged and no second frame follows.
- R10: A length value of 2 or less sends no payload. The check bytes that follow are 0x00, 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame; accepted only when idle |
| fifo_data_i | input | 8 | Head word of the transmit FIFO |
| fifo_valid_i | input | 1 | FIFO head word is present |
| fifo_pop_o | output | 1 | Head word consumed this cycle |
| tx_byte_o | output | 8 | Byte offered to the modulator |
| tx_valid_o | output | 1 | `tx_byte_o` is valid |
| tx_ready_i | input | 1 | Modulator takes the byte this cycle |
| sfd_o | output | 1 | Delimiter sent, frame still running |
| sfd_irq_o | output | 1 | One-cycle pulse at delimiter completion |
| underflow_o | output | 1 | Last frame aborted for lack of FIFO data |

## Verification
- **Combinational results:** `tx_byte_o`, `tx_valid_o` and `fifo_pop_o` follow the current state and the same-cycle inputs. The bench therefore drives `tx_ready_i` on the falling edge and reads these outputs 1 ns later, counting a transfer for the edge that follows.
- **Registered flags:** `sfd_o`, `sfd_irq_o` and `underflow_o` change one edge after their cause. The bench tags each flag change with the number of transfers already completed and whether the previous sample was a transfer. A delimiter flag that arrives one byte early or late is therefore seen as a wrong position.
- **Back-pressure:** random back-pressure is checked by comparing each held byte with the byte offered at the next sample.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_LEN,
    ST_PAY,
    ST_CRC_LO,
    ST_CRC_HI
  } txf_state_e;

endpackage

// File: rtl/txf_crc16.sv
module txf_crc16 #(
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] SEED     = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;
  logic [15:0] crc_nxt;

  // Reflected shift register: data bit 0 enters first.
  always_comb begin
    crc_nxt = crc_q;
    for (int b = 0; b < 8; b++) begin
      crc_nxt = {1'b0, crc_nxt[15:1]} ^ ({16{crc_nxt[0] ^ din_i[b]}} & POLY_REV);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= SEED;
    else if (clr_i) crc_q <= SEED;
    else if (en_i)  crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_q == SEED)); // R4

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import tx_frame_pkg::*;
#(
  parameter int PRE_BYTES = 4,
  parameter int LEN_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fifo_valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tx_ready_i,
  output txf_state_e       state_o,
  output logic             tx_valid_o,
  output logic             fifo_pop_o,
  output logic             start_acc_o,
  output logic             crc_en_o,
  output logic             sfd_sent_o,
  output logic             last_sent_o,
  output logic             abort_o
);

  localparam int PCW = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam logic [PCW-1:0]   PRE_LAST  = PCW'(PRE_BYTES - 1);
  localparam logic [LEN_W-1:0] CRC_BYTES = LEN_W'(2);

  txf_state_e       state_q;
  txf_state_e       state_d;
  logic [PCW-1:0]   pre_cnt_q;
  logic [PCW-1:0]   pre_cnt_d;
  logic [LEN_W-1:0] pay_left_q;
  logic [LEN_W-1:0] pay_left_d;

  logic from_fifo;
  logic xfer;
  logic starve;

  assign from_fifo  = (state_q == ST_LEN) || (state_q == ST_PAY);
  assign tx_valid_o = (state_q != ST_IDLE) && (!from_fifo || fifo_valid_i);
  assign xfer       = tx_valid_o && tx_ready_i;
  assign starve     = from_fifo && tx_ready_i && !fifo_valid_i;

  assign fifo_pop_o  = from_fifo && xfer;
  assign start_acc_o = (state_q == ST_IDLE) && start_i;
  assign crc_en_o    = (state_q == ST_PAY) && xfer;
  assign sfd_sent_o  = (state_q == ST_SFD) && xfer;
  assign last_sent_o = (state_q == ST_CRC_HI) && xfer;
  assign abort_o     = starve;
  assign state_o     = state_q;

  always_comb begin
    state_d    = state_q;
    pre_cnt_d  = pre_cnt_q;
    pay_left_d = pay_left_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_PRE;
          pre_cnt_d = '0;
        end
      end
      ST_PRE: begin
        if (xfer) begin
          if (pre_cnt_q == PRE_LAST) state_d = ST_SFD;
          else                       pre_cnt_d = pre_cnt_q + 1'b1;
        end
      end
      ST_SFD: begin
        if (xfer) state_d = ST_LEN;
      end
      ST_LEN: begin
        if (starve) begin
          state_d = ST_IDLE;
        end else if (xfer) begin
          if (len_i <= CRC_BYTES) begin
            state_d    = ST_CRC_LO;
            pay_left_d = '0;
          end else begin
            state_d    = ST_PAY;
            pay_left_d = len_i - CRC_BYTES;
          end
        end
      end
      ST_PAY: begin
        if (starve) begin
          state_d = ST_IDLE;
        end else if (xfer) begin
          pay_left_d = pay_left_q - 1'b1;
          if (pay_left_q == LEN_W'(1)) state_d = ST_CRC_LO;
        end
      end
      ST_CRC_LO: begin
        if (xfer) state_d = ST_CRC_HI;
      end
      ST_CRC_HI: begin
        if (xfer) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pre_cnt_q  <= '0;
      pay_left_q <= '0;
    end else begin
      state_q    <= state_d;
      pre_cnt_q  <= pre_cnt_d;
      pay_left_q <= pay_left_d;
    end
  end

  AST_PAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY) |-> (pay_left_q != '0)); // R3

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (state_q == ST_IDLE) && !tx_valid_o); // R8

  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q == ST_PAY) && !tx_ready_i) |=> (state_q == ST_PAY)); // R9

  AST_HEADER_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PRE) || (state_q == ST_SFD)) |-> !fifo_pop_o); // R2

endmodule

// File: rtl/txf_status.sv
module txf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc_i,
  input  logic sfd_sent_i,
  input  logic last_sent_i,
  input  logic abort_i,
  output logic sfd_o,
  output logic irq_o,
  output logic underflow_o
);

  logic sfd_q;
  logic irq_q;
  logic uflow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfd_q   <= 1'b0;
      irq_q   <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      irq_q <= sfd_sent_i;
      if (sfd_sent_i)                  sfd_q <= 1'b1;
      else if (last_sent_i || abort_i) sfd_q <= 1'b0;
      if (abort_i)          uflow_q <= 1'b1;
      else if (start_acc_i) uflow_q <= 1'b0;
    end
  end

  assign sfd_o       = sfd_q;
  assign irq_o       = irq_q;
  assign underflow_o = uflow_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R6

  AST_IRQ_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sfd_q) |-> irq_q); // R6

  AST_UFLOW_NO_SFD: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_q |-> !sfd_q); // R8

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_frame_pkg::*;
#(
  parameter int          PRE_BYTES = 4,
  parameter logic [7:0]  PRE_VAL   = 8'h00,
  parameter logic [7:0]  SFD_VAL   = 8'hA7,
  parameter int          LEN_W     = 7,
  parameter logic [15:0] POLY_REV  = 16'h8408
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] fifo_data_i,
  input  logic       fifo_valid_i,
  output logic       fifo_pop_o,
  output logic [7:0] tx_byte_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic       sfd_o,
  output logic       sfd_irq_o,
  output logic       underflow_o
);

  txf_state_e  state;
  logic        start_acc;
  logic        crc_en;
  logic        sfd_sent;
  logic        last_sent;
  logic        abort;
  logic [15:0] crc;

  txf_ctrl #(
    .PRE_BYTES (PRE_BYTES),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .fifo_valid_i (fifo_valid_i),
    .len_i        (fifo_data_i[LEN_W-1:0]),
    .tx_ready_i   (tx_ready_i),
    .state_o      (state),
    .tx_valid_o   (tx_valid_o),
    .fifo_pop_o   (fifo_pop_o),
    .start_acc_o  (start_acc),
    .crc_en_o     (crc_en),
    .sfd_sent_o   (sfd_sent),
    .last_sent_o  (last_sent),
    .abort_o      (abort)
  );

  txf_crc16 #(
    .POLY_REV (POLY_REV),
    .SEED     (16'h0000)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_acc),
    .en_i  (crc_en),
    .din_i (fifo_data_i),
    .crc_o (crc)
  );

  txf_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_acc_i (start_acc),
    .sfd_sent_i  (sfd_sent),
    .last_sent_i (last_sent),
    .abort_i     (abort),
    .sfd_o       (sfd_o),
    .irq_o       (sfd_irq_o),
    .underflow_o (underflow_o)
  );

  always_comb begin
    unique case (state)
      ST_PRE:    tx_byte_o = PRE_VAL;
      ST_SFD:    tx_byte_o = SFD_VAL;
      ST_LEN,
      ST_PAY:    tx_byte_o = fifo_data_i;
      ST_CRC_LO: tx_byte_o = crc[7:0];
      ST_CRC_HI: tx_byte_o = crc[15:8];
      default:   tx_byte_o = 8'h00;
    endcase
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i && (state != ST_LEN) && (state != ST_PAY))
      |=> tx_valid_o && $stable(tx_byte_o)); // R5

  AST_POP_IS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> (tx_valid_o && tx_ready_i && fifo_valid_i)); // R3

endmodule

// File: tb/tb_tx_frame_seq.sv
module tb_tx_frame_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] fifo_data_i;
  logic       fifo_valid_i;
  logic       fifo_pop_o;
  logic [7:0] tx_byte_o;
  logic       tx_valid_o;
  logic       tx_ready_i = 1'b0;
  logic       sfd_o;
  logic       sfd_irq_o;
  logic       underflow_o;

  always #5 clk = ~clk;

  tx_frame_seq dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_valid_i (fifo_valid_i),
    .fifo_pop_o   (fifo_pop_o),
    .tx_byte_o    (tx_byte_o),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i),
    .sfd_o        (sfd_o),
    .sfd_irq_o    (sfd_irq_o),
    .underflow_o  (underflow_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Bench FIFO: tasks push at fwr, the pop process advances frd.
  logic [7:0] fmem [0:1023];
  int fwr = 0;
  int frd = 0;
  assign fifo_valid_i = (frd < fwr);
  assign fifo_data_i  = fmem[frd % 1024];
  always @(posedge clk) if (fifo_pop_o) frd <= frd + 1;

  // Modulator model and observer.
  int         rdy_mode = 0;
  logic [7:0] cap [0:4095];
  int         xfers = 0;
  int         irq_cnt = 0;
  int         irq_at = -1;
  int         irq_prev = 0;
  int         fall_cnt = 0;
  int         fall_at = -1;
  int         fall_prev = 0;
  int         hold_err = 0;
  logic       last_xfer = 1'b0;
  logic       sfd_seen = 1'b0;
  logic       hold_pend = 1'b0;
  logic [7:0] held = 8'h00;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
    #1;
    if (hold_pend && (!tx_valid_o || tx_byte_o != held)) hold_err++;
    if (sfd_irq_o) begin
      irq_cnt++;
      irq_at   = xfers;
      irq_prev = last_xfer;
    end
    if (sfd_seen && !sfd_o) begin
      fall_cnt++;
      fall_at   = xfers;
      fall_prev = last_xfer;
    end
    sfd_seen  = sfd_o;
    hold_pend = tx_valid_o && !tx_ready_i;
    held      = tx_byte_o;
    if (tx_valid_o && tx_ready_i) begin
      cap[xfers % 4096] = tx_byte_o;
      xfers++;
      last_xfer = 1'b1;
    end else begin
      last_xfer = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic push(input logic [7:0] v);
    fmem[fwr % 1024] = v;
    fwr++;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(input int fall0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fall_cnt != fall0 || underflow_o) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Full frame: length byte lb, payload count derived from lb[6:0].
  task automatic t_frame(input logic [7:0] lb, input int mode, input int seed,
                         input bit busy_start, input string req);
    logic [7:0]  exp [0:199];
    logic [15:0] crc;
    int          n_pay;
    int          n_tot;
    int          base;
    int          irq0;
    int          fall0;
    int          rd0;
    int          bad_idx;
    n_pay = (lb[6:0] > 2) ? int'(lb[6:0]) - 2 : 0;
    crc   = 16'h0000;
    for (int k = 0; k < 4; k++) exp[k] = 8'h00;
    exp[4] = 8'hA7;
    exp[5] = lb;
    push(lb);
    for (int k = 0; k < n_pay; k++) begin
      logic [7:0] v;
      v = 8'((seed * 29 + k * 13 + 5) & 255);
      push(v);
      exp[6 + k] = v;
      crc = crc_step(crc, v);
    end
    exp[6 + n_pay] = crc[7:0];
    exp[7 + n_pay] = crc[15:8];
    n_tot = 8 + n_pay;
    rdy_mode = mode;
    base  = xfers;
    irq0  = irq_cnt;
    fall0 = fall_cnt;
    rd0   = frd;
    pulse_start();
    if (busy_start) begin
      repeat (8) @(negedge clk);
      pulse_start();
    end
    wait_end(fall0);
    if (busy_start) begin
      repeat (40) @(negedge clk);
      chk(xfers - base == n_tot, "R9 no second frame", xfers - base, n_tot);
    end
    bad_idx = -1;
    for (int k = 0; k < n_tot; k++)
      if (bad_idx < 0 && cap[(base + k) % 4096] != exp[k]) bad_idx = k;
    chk(xfers - base == n_tot, {req, " byte count"}, xfers - base, n_tot);
    if (bad_idx >= 0)
      chk(1'b0, {req, " stream byte"}, cap[(base + bad_idx) % 4096], exp[bad_idx]);
    else
      chk(1'b1, req, 0, 0);
    chk(cap[(base + 4) % 4096] == 8'hA7, "R2 delimiter", cap[(base + 4) % 4096], 8'hA7);
    chk(frd - rd0 == n_pay + 1, "R3 pop count", frd - rd0, n_pay + 1);
    chk(cap[(base + n_tot - 2) % 4096] == crc[7:0] &&
        cap[(base + n_tot - 1) % 4096] == crc[15:8], "R4 crc bytes",
        {cap[(base + n_tot - 1) % 4096], cap[(base + n_tot - 2) % 4096]}, crc);
    chk(irq_cnt - irq0 == 1 && irq_at == base + 5 && irq_prev == 1, "R6 irq position",
        irq_at - base, 5);
    chk(fall_cnt - fall0 == 1 && fall_at == base + n_tot && fall_prev == 1,
        "R7 sfd fall position", fall_at - base, n_tot);
    chk(!tx_valid_o && !sfd_o, "R7 idle after frame", {tx_valid_o, sfd_o}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid_o && !fifo_pop_o && !sfd_o && !sfd_irq_o && !underflow_o,
        "R1 reset outputs",
        {tx_valid_o, fifo_pop_o, sfd_o, sfd_irq_o, underflow_o}, 0);
  endtask

  task automatic t_stall();
    int base;
    rdy_mode = 2;
    base = xfers;
    push(8'h04);
    push(8'h11);
    push(8'h22);
    pulse_start();
    repeat (10) @(negedge clk);
    chk(xfers == base && tx_valid_o && tx_byte_o == 8'h00, "R5 stalled preamble",
        tx_byte_o, 8'h00);
    rdy_mode = 0;
    wait_end(fall_cnt);
    chk(xfers - base == 10, "R5 frame after stall", xfers - base, 10);
  endtask

  task automatic t_underflow();
    int base;
    rdy_mode = 0;
    base = xfers;
    push(8'h0A);
    for (int k = 0; k < 4; k++) push(8'(8'h40 + k));
    pulse_start();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (underflow_o) break;
    end
    chk(underflow_o && !sfd_o && !tx_valid_o, "R8 abort state",
        {underflow_o, sfd_o, tx_valid_o}, 3'b100);
    chk(xfers - base == 10, "R8 bytes before abort", xfers - base, 10);
    repeat (5) @(negedge clk);
    chk(underflow_o, "R8 flag holds", underflow_o, 1);
    rdy_mode = 2;
    push(8'h02);
    pulse_start();
    chk(!underflow_o, "R8 flag cleared by start", underflow_o, 0);
    rdy_mode = 0;
    wait_end(fall_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame(8'h0A, 0, 1, 1'b0, "R2 R3 frame len10");
    t_frame(8'h16, 1, 2, 1'b0, "R5 frame random ready");
    chk(hold_err == 0, "R5 held byte stable", hold_err, 0);
    t_frame(8'h85, 1, 3, 1'b0, "R3 len bit7 ignored");
    t_frame(8'h02, 0, 4, 1'b0, "R10 empty payload");
    t_frame(8'h01, 0, 5, 1'b0, "R10 len below two");
    t_frame(8'h0C, 0, 6, 1'b1, "R9 busy start");
    t_stall();
    t_underflow();
    t_frame(8'h07, 1, 7, 1'b0, "R4 frame after abort");
    chk(hold_err == 0, "R5 held byte stable overall", hold_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule